// File: doc/BRIEF.md
# DMA Command-Queue Register Block

This block is the software-visible register face of a host-to-controller DMA engine's command queue. It holds a queue end pointer, a write pointer and a read pointer, an interrupt enable register and an interrupt status register, and it drives a level interrupt. Reads and writes arrive on a simple word-addressed register bus. The bus has a request strobe, a write flag, a byte address, and write data. Read data is returned combinationally from the addressed word.

No data is actually moved. When the host writes the write pointer, that value is mirrored into the read pointer, and completion is reported at once: both completion bits are set in the status register. The interrupt is raised if either completion enable is set. Writing a special key value to the read pointer beforehand swallows exactly one such completion.

Register offsets, the enable write mask, the pointer write mask, the key value and the position of the completion bit pair are elaboration parameters. Two silicon variants can therefore be built from one source.

Top module: `dmaq_regs`

## Requirements
- R1: After reset every register reads zero except status, which reads 0xF8000000, and `irq_o` is low.
- R2: A write to the end-pointer offset (default 0x18) stores the data ANDed with the pointer mask (default 0x00FFFFF8).
- R3: A write to the write-pointer offset (default 0x1C) stores the masked data and loads the same value into the read pointer (default 0x20) in the same cycle.
- R4: A write to the read-pointer offset never changes its stored value. A value other than the key (default 0xC0DE0001) arms nothing.
- R5: Writing the key to the read pointer makes the next write-pointer write report no completion. The arming is consumed by that write, so the following write-pointer write completes normally.
- R6: A write-pointer write that is not suppressed sets both completion bits in status (bits CMP_LO and CMP_LO+1, default 16 and 17). All other status bits are left unchanged.
- R7: At a completion, `irq_o` goes high in the next cycle if the enable register has either completion bit set, and stays low otherwise.
- R8: A status write with either completion bit set clears both completion bits and drops `irq_o`. A status write with neither bit set changes nothing.
- R9: A write to the enable offset (default 0x38) stores the data ANDed with the enable mask parameter.
- R10: A write to any other word inside the 0x7C-byte window stores the full 32 bits, and reads return them unchanged.
- R11: Writes at byte offset 0x7C or above are ignored, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Level completion interrupt |

## Verification
The bench uses the newer-variant offsets and keeps completion bits at 16 and 17. It widens the enable mask to 0x017303FF. With the stock mask 0x017003FF, the two completion enables can never be written, so the interrupt could never rise. The wider mask still checks the masking against the bits it drops, and it makes the rising and clearing of `irq_o` reachable. The pointer mask and the key keep their defaults. Together they cover key-armed suppression, its one-shot consumption, and non-key writes to the read pointer.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int unsigned DW = 32;
  typedef logic [DW-1:0] word_t;
  localparam word_t STS_RST = 32'hF800_0000;
  localparam int unsigned WIN_BYTES = 'h7C;
endpackage

// File: rtl/dmaq_ptr_regs.sv
module dmaq_ptr_regs
  import dmaq_pkg::*;
#(
  parameter word_t PTR_MASK = 32'h00FF_FFF8,
  parameter word_t KEY      = 32'hC0DE_0001
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  end_we_i,
  input  logic  wrp_we_i,
  input  logic  rdp_we_i,
  input  word_t wdata_i,
  output word_t end_o,
  output word_t wrp_o,
  output word_t rdp_o,
  output logic  cmp_evt_o
);
  word_t end_q, wrp_q, rdp_q;
  logic  supp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_q  <= '0;
      wrp_q  <= '0;
      rdp_q  <= '0;
      supp_q <= 1'b0;
    end else begin
      if (end_we_i) end_q <= wdata_i & PTR_MASK;
      if (wrp_we_i) begin
        wrp_q  <= wdata_i & PTR_MASK;
        rdp_q  <= wdata_i & PTR_MASK;
        supp_q <= 1'b0;
      end else if (rdp_we_i && wdata_i == KEY) begin
        supp_q <= 1'b1;
      end
    end
  end

  assign cmp_evt_o = wrp_we_i & ~supp_q;
  assign end_o = end_q;
  assign wrp_o = wrp_q;
  assign rdp_o = rdp_q;

  // R3
  wrp_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrp_we_i |=> rdp_q == wrp_q);
  // R5
  supp_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrp_we_i && supp_q) |=> !supp_q);
  // R4
  rdp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdp_we_i && !wrp_we_i) |=> $stable(rdp_q));
endmodule

// File: rtl/dmaq_irq_regs.sv
module dmaq_irq_regs
  import dmaq_pkg::*;
#(
  parameter word_t       ENA_MASK = 32'h0170_03FF,
  parameter int unsigned CMP_LO   = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmp_evt_i,
  input  logic  ena_we_i,
  input  logic  sts_we_i,
  input  word_t wdata_i,
  output word_t ena_o,
  output word_t sts_o,
  output logic  irq_o
);
  localparam word_t CMP_MASK = word_t'(32'h3) << CMP_LO;

  word_t ena_q, sts_q;
  logic  irq_q;
  logic  clr_hit;

  assign clr_hit = sts_we_i && |(wdata_i & CMP_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q <= '0;
      sts_q <= STS_RST;
      irq_q <= 1'b0;
    end else begin
      if (ena_we_i) ena_q <= wdata_i & ENA_MASK;
      if (cmp_evt_i) begin
        sts_q <= sts_q | CMP_MASK;
        if (|(ena_q & CMP_MASK)) irq_q <= 1'b1;
      end else if (clr_hit) begin
        sts_q <= sts_q & ~CMP_MASK;
        irq_q <= 1'b0;
      end
    end
  end

  assign ena_o = ena_q;
  assign sts_o = sts_q;
  assign irq_o = irq_q;

  // R6
  cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_i |=> (sts_q & CMP_MASK) == CMP_MASK);
  // R8
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && !cmp_evt_i) |=> !irq_q);
  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(cmp_evt_i));
endmodule

// File: rtl/dmaq_gen_regs.sv
module dmaq_gen_regs
  import dmaq_pkg::*;
#(
  parameter int unsigned NWORDS = 31,
  parameter int unsigned IDX_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  word_t            wdata_i,
  output word_t            rdata_o
);
  word_t mem_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))         mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NWORDS; i++)
      if (idx_i == IDX_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/dmaq_regs.sv
module dmaq_regs
  import dmaq_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] END_OFS = 8'h18,
  parameter logic [ADDR_W-1:0] WRP_OFS = 8'h1C,
  parameter logic [ADDR_W-1:0] RDP_OFS = 8'h20,
  parameter logic [ADDR_W-1:0] ENA_OFS = 8'h38,
  parameter logic [ADDR_W-1:0] STS_OFS = 8'h3C,
  parameter word_t           ENA_MASK = 32'h0170_03FF,
  parameter word_t           PTR_MASK = 32'h00FF_FFF8,
  parameter word_t           KEY      = 32'hC0DE_0001,
  parameter int unsigned     CMP_LO   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned NWORDS = WIN_BYTES / 4;

  logic in_win, wr, hit_end, hit_wrp, hit_rdp, hit_ena, hit_sts, hit_special;
  logic cmp_evt;
  word_t end_w, wrp_w, rdp_w, ena_w, sts_w, gen_w;

  assign in_win      = 32'(addr_i) < WIN_BYTES;
  assign wr          = req_i & we_i & in_win;
  assign hit_end     = addr_i == END_OFS;
  assign hit_wrp     = addr_i == WRP_OFS;
  assign hit_rdp     = addr_i == RDP_OFS;
  assign hit_ena     = addr_i == ENA_OFS;
  assign hit_sts     = addr_i == STS_OFS;
  assign hit_special = hit_end | hit_wrp | hit_rdp | hit_ena | hit_sts;

  dmaq_ptr_regs #(.PTR_MASK(PTR_MASK), .KEY(KEY)) u_ptr (
    .clk_i, .rst_ni,
    .end_we_i (wr & hit_end),
    .wrp_we_i (wr & hit_wrp),
    .rdp_we_i (wr & hit_rdp),
    .wdata_i,
    .end_o    (end_w),
    .wrp_o    (wrp_w),
    .rdp_o    (rdp_w),
    .cmp_evt_o(cmp_evt)
  );

  dmaq_irq_regs #(.ENA_MASK(ENA_MASK), .CMP_LO(CMP_LO)) u_irq (
    .clk_i, .rst_ni,
    .cmp_evt_i(cmp_evt),
    .ena_we_i (wr & hit_ena),
    .sts_we_i (wr & hit_sts),
    .wdata_i,
    .ena_o    (ena_w),
    .sts_o    (sts_w),
    .irq_o
  );

  dmaq_gen_regs #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_gen (
    .clk_i, .rst_ni,
    .we_i   (wr & ~hit_special),
    .idx_i  (addr_i[ADDR_W-1:2]),
    .wdata_i,
    .rdata_o(gen_w)
  );

  always_comb begin
    if (!in_win)      rdata_o = '0;
    else if (hit_end) rdata_o = end_w;
    else if (hit_wrp) rdata_o = wrp_w;
    else if (hit_rdp) rdata_o = rdp_w;
    else if (hit_ena) rdata_o = ena_w;
    else if (hit_sts) rdata_o = sts_w;
    else              rdata_o = gen_w;
  end

  // R11
  oob_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !in_win) |=> ($stable(end_w) && $stable(wrp_w) &&
                                   $stable(ena_w) && $stable(sts_w)));
  // R1
  rst_irq_chk: assert property (@(posedge clk_i) !rst_ni |-> !irq_o);
endmodule

// File: tb/dmaq_regs_tb.sv
`timescale 1ns/1ps
module dmaq_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic pend = 1'b0;
  logic done = 1'b0;

  typedef struct { logic [31:0] exp; logic irq_exp; string tag; } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  dmaq_regs #(.ENA_MASK(32'h0173_03FF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input logic ie, input string t);
    item_t it;
    @(posedge clk); #1;
    addr = a; req = 1'b1; we = 1'b0;
    it.exp = e; it.irq_exp = ie; it.tag = t;
    sbq.push_back(it);
    pend = 1'b1;
    @(posedge clk); #1;
    pend = 1'b0; req = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (pend && sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        n_chk++;
        if (rdata !== it.exp || irq !== it.irq_exp) begin
          n_bad++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   it.tag, rdata, irq, it.exp, it.irq_exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(8'h3C, 32'hF800_0000, 1'b0, "R1 status");
    rd(8'h18, 32'h0, 1'b0, "R1 end");
    rd(8'h1C, 32'h0, 1'b0, "R1 wrp");
    rd(8'h20, 32'h0, 1'b0, "R1 rdp");
    rd(8'h38, 32'h0, 1'b0, "R1 enable");
    // R2
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h00FF_FFF8, 1'b0, "R2 end mask");
    // R9
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, 32'h0173_03FF, 1'b0, "R9 enable mask");
    wr(8'h38, 32'h0);
    rd(8'h38, 32'h0, 1'b0, "R9 enable clear");
    // R3 / R6 / R7 (no enable)
    wr(8'h1C, 32'h1234_567F);
    rd(8'h1C, 32'h0034_5678, 1'b0, "R3 wrp stored");
    rd(8'h20, 32'h0034_5678, 1'b0, "R3 rdp mirrored");
    rd(8'h3C, 32'hF803_0000, 1'b0, "R6 completion bits, R7 disabled");
    // R8
    wr(8'h3C, 32'h0000_0001);
    rd(8'h3C, 32'hF803_0000, 1'b0, "R8 no-op status write");
    wr(8'h3C, 32'h0001_0000);
    rd(8'h3C, 32'hF800_0000, 1'b0, "R8 clear both");
    // R4
    wr(8'h20, 32'h1111_1110);
    rd(8'h20, 32'h0034_5678, 1'b0, "R4 rdp not stored");
    wr(8'h1C, 32'h0000_0100);
    rd(8'h3C, 32'hF803_0000, 1'b0, "R4 non-key arms nothing");
    wr(8'h3C, 32'h0002_0000);
    // R5 suppression then one-shot, R7 enable
    wr(8'h38, 32'h0002_0000);
    wr(8'h20, 32'hC0DE_0001);
    wr(8'h1C, 32'h0000_0200);
    rd(8'h3C, 32'hF800_0000, 1'b0, "R5 suppressed completion");
    rd(8'h20, 32'h0000_0200, 1'b0, "R5 rdp still mirrored");
    wr(8'h1C, 32'h0000_0208);
    rd(8'h3C, 32'hF803_0000, 1'b1, "R5 one-shot consumed, R7 irq high");
    wr(8'h3C, 32'h0000_0004);
    rd(8'h3C, 32'hF803_0000, 1'b1, "R8 irq kept on no-op write");
    wr(8'h3C, 32'h0002_0000);
    rd(8'h3C, 32'hF800_0000, 1'b0, "R8 irq dropped");
    // R10
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h40, 32'hDEAD_BEEF, 1'b0, "R10 plain word");
    wr(8'h00, 32'h8000_0001);
    rd(8'h00, 32'h8000_0001, 1'b0, "R10 word zero");
    // R11
    wr(8'h7C, 32'hA5A5_A5A5);
    rd(8'h7C, 32'h0, 1'b0, "R11 out of window read");
    wr(8'hBC, 32'h0003_0000);
    rd(8'h3C, 32'hF800_0000, 1'b0, "R11 status untouched");
    rd(8'h40, 32'hDEAD_BEEF, 1'b0, "R11 window intact");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule